// File: doc/BRIEF.md
# Key Autorepeat Marker Generator

This block decides when a held key should produce a repeat marker in a key-event queue. It counts debounce-cycle ticks while at least one key stays down. It asks the queue to store a repeat marker first after an initial delay and then at a steady interval. It never re-enters the held key's own code. It only raises a one-cycle push request, and the queue stores a generic repeat marker in response.

Every recorded press or release starts the timing again. On that event the block also captures the 8-bit setting byte. Bit 7 of the byte is the enable. Bits [3:0] set the initial delay in steps of 8 ticks, and bits [6:4] set the repeat interval in steps of 4 ticks. Because the delay restarts on every event, a release that leaves other keys down begins a fresh delay. The debouncer and the queue storage sit outside this block.

Top module: `key_autorepeat`

## Requirements
- R1: After reset `rpt_push` is 0 and the captured setting is all zeros (repeat disabled), so no push occurs before the first key event, even if keys are held and ticks arrive.
- R2: Bit 7 of the captured setting enables repeat markers when it is 1. When it is 0, no push is produced.
- R3: With repeat enabled and a key held, the first push comes after (bits[3:0]+1)×8 ticks counted from the last key event. That is 8 ticks for code 0 and 128 ticks for code 15. The push is high in the cycle after the clock edge that takes the final tick.
- R4: After the first push, further pushes come every (bits[6:4]+1)×4 ticks, from 4 up to 32. They continue until the next key event, which starts the initial delay again.
- R5: A cycle with `key_held` at 0 clears the tick count and the repeat phase. No push is produced while no key is held, and the full delay applies again once a key is held.
- R6: A release event with `key_held` still 1 restarts the initial delay from zero.
- R7: `cfg` is sampled only in a cycle with `key_evt` at 1. Changes between events have no effect on timing or on the enable.
- R8: Only cycles with `tick` at 1 advance the count. A cycle with both `key_evt` and `tick` at 1 counts as an event, and that tick is not counted.
- R9: `rpt_push` is high for exactly one cycle per marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse per debounce cycle |
| key_held | input | 1 | 1 while any key is debounced as pressed |
| key_evt | input | 1 | One-cycle strobe when a press or release is recorded |
| cfg | input | 8 | Setting byte: [7] enable, [6:4] interval code, [3:0] delay code |
| rpt_push | output | 1 | One-cycle request to push a repeat marker |

## Verification
A push is registered. It appears one cycle after the edge that takes the final tick of the delay or the interval, and it stays for that single cycle. The driver sets the inputs at the falling edge. For every tick whose count completes a period, it files the index of the next rising edge as the expected cycle. The monitor samples `rpt_push` at the falling edge within that cycle. It flags any push that has no matching expected cycle, and any expected cycle that passes without a push.

// File: rtl/key_autorepeat.sv
module key_autorepeat #(
  parameter int CNT_W     = 8,
  parameter int DLY_SHIFT = 3,
  parameter int INT_SHIFT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       key_held,
  input  logic       key_evt,
  input  logic [7:0] cfg,
  output logic       rpt_push
);
  logic [7:0]       cfg_q;
  logic [CNT_W-1:0] cnt;
  logic             rep;

  logic [CNT_W-1:0] delay_len, intv_len, target, cnt_nxt;
  logic             active, hit;

  assign delay_len = CNT_W'({1'b0, cfg_q[3:0]} + 5'd1) << DLY_SHIFT;
  assign intv_len  = CNT_W'({2'b0, cfg_q[6:4]} + 5'd1) << INT_SHIFT;
  assign target    = rep ? intv_len : delay_len;
  assign cnt_nxt   = cnt + 1'b1;
  assign hit       = cnt_nxt == target;
  assign active    = key_held && cfg_q[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      cnt      <= '0;
      rep      <= 1'b0;
      rpt_push <= 1'b0;
    end else begin
      rpt_push <= 1'b0;
      if (key_evt) begin
        cfg_q <= cfg;
        cnt   <= '0;
        rep   <= 1'b0;
      end else if (!active) begin
        cnt <= '0;
        rep <= 1'b0;
      end else if (tick) begin
        if (hit) begin
          rpt_push <= 1'b1;
          cnt      <= '0;
          rep      <= 1'b1;
        end else begin
          cnt <= cnt_nxt;
        end
      end
    end
  end
endmodule

module key_autorepeat_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic key_held,
  input logic key_evt,
  input logic en_q,
  input logic rpt_push
);
  a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_push |=> !rpt_push);
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !key_held |=> !rpt_push);
  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    key_evt |=> !rpt_push);
  a_r8_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !rpt_push);
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !rpt_push);
endmodule

bind key_autorepeat key_autorepeat_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .key_held(key_held),
  .key_evt(key_evt), .en_q(cfg_q[7]), .rpt_push(rpt_push)
);

// File: tb/key_autorepeat_tb_top.sv
module key_autorepeat_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, key_held = 1'b0, key_evt = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic rpt_push;

  int cyc = 0;
  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  int    exp_q[$];
  string tag_q[$];

  int         since = 0;
  logic [7:0] mcfg = 8'h00;
  logic [7:0] cur_cfg = 8'h00;

  key_autorepeat dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .key_held(key_held),
    .key_evt(key_evt), .cfg(cfg), .rpt_push(rpt_push)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic step(input bit t, input bit h, input bit e, input string tag);
    int d, iv;
    @(negedge clk);
    tick = t; key_held = h; key_evt = e; cfg = cur_cfg;
    if (e) begin
      mcfg = cur_cfg;
      since = 0;
    end else if (!h || !mcfg[7]) begin
      since = 0;
    end else if (t) begin
      since++;
      d  = (int'(mcfg[3:0]) + 1) * 8;
      iv = (int'(mcfg[6:4]) + 1) * 4;
      if (since == d || (since > d && (since - d) % iv == 0)) begin
        exp_q.push_back(cyc + 1);
        tag_q.push_back(tag);
      end
    end
  endtask

  task automatic ticks(input int n, input bit h, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, h, 1'b0, tag);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      while (exp_q.size() > 0 && exp_q[0] < cyc) begin
        checks++; bad++;
        $display("FAIL %s: missed push, actual=0 expected=1 at cycle %0d", tag_q[0], exp_q[0]);
        void'(exp_q.pop_front()); void'(tag_q.pop_front());
      end
      if (rpt_push) begin
        checks++;
        if (exp_q.size() > 0 && exp_q[0] == cyc) begin
          void'(exp_q.pop_front()); void'(tag_q.pop_front());
        end else begin
          bad++;
          $display("FAIL R9/R3: unexpected push, actual=1 expected=0 at cycle %0d", cyc);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rpt_push !== 1'b0) begin
      bad++; $display("FAIL R1: reset push actual=%b expected=0", rpt_push);
    end
    rst_n = 1'b1;

    // R1: held and ticking before any event: nothing
    ticks(20, 1'b1, "R1");

    // R2 R3 R4: delay 8, interval 4
    cur_cfg = 8'h80;
    step(1'b0, 1'b1, 1'b1, "R3");
    ticks(21, 1'b1, "R4");

    // R3 boundary: delay 128, interval 32
    cur_cfg = 8'hFF;
    step(1'b0, 1'b1, 1'b1, "R3");
    ticks(200, 1'b1, "R3");

    // R2: disabled
    cur_cfg = 8'h0F;
    step(1'b0, 1'b1, 1'b1, "R2");
    ticks(60, 1'b1, "R2");

    // R5: held drops mid-delay, then full delay again
    cur_cfg = 8'h81;
    step(1'b0, 1'b1, 1'b1, "R5");
    ticks(10, 1'b1, "R5");
    step(1'b1, 1'b0, 1'b0, "R5");
    ticks(5, 1'b0, "R5");
    ticks(20, 1'b1, "R5");

    // R6: release with keys still held restarts delay
    cur_cfg = 8'h90;
    step(1'b0, 1'b1, 1'b1, "R6");
    ticks(6, 1'b1, "R6");
    step(1'b0, 1'b1, 1'b1, "R6");
    ticks(20, 1'b1, "R6");

    // R4: event during repeat phase stops markers, restarts delay
    cur_cfg = 8'hA0;
    step(1'b0, 1'b1, 1'b1, "R4");
    ticks(13, 1'b1, "R4");
    step(1'b0, 1'b1, 1'b1, "R4");
    ticks(12, 1'b1, "R4");

    // R7: cfg change without event ignored (incl. disable)
    cur_cfg = 8'h80;
    step(1'b0, 1'b1, 1'b1, "R7");
    cur_cfg = 8'h0F;
    ticks(16, 1'b1, "R7");
    step(1'b0, 1'b1, 1'b1, "R7");
    cur_cfg = 8'h80;
    ticks(20, 1'b1, "R7");

    // R8: non-tick cycles do not count; event beats tick
    cur_cfg = 8'h80;
    step(1'b0, 1'b1, 1'b1, "R8");
    for (int i = 0; i < 14; i++) begin
      step(1'b1, 1'b1, 1'b0, "R8");
      step(1'b0, 1'b1, 1'b0, "R8");
      step(1'b0, 1'b1, 1'b0, "R8");
    end
    ticks(7, 1'b1, "R8");
    step(1'b1, 1'b1, 1'b1, "R8");
    ticks(9, 1'b1, "R8");

    step(1'b0, 1'b0, 1'b0, "R5");
    repeat (4) step(1'b0, 1'b0, 1'b0, "R5");
    @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      bad++; $display("FAIL R3: pending pushes actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule